// File: doc/BRIEF.md
# Jump Condition and Input Handshake Unit

This unit decides whether a conditional jump is taken and which address source the jump uses. It also holds the byte received from an external input port, together with the input-available flag that guards that byte. The control path presents the jump opcode's lower nibble, a flag that marks the current instruction as a jump, and the arithmetic status byte. The unit answers in the same cycle with a take decision and a source select. The select is 0 for the H:L register pair and 1 for a 16-bit immediate address.

The input side accepts a byte on a single-cycle valid strobe, but only while the input-available flag is clear. Once a byte is taken, the flag is set and further bytes are refused until the CPU reads the input register. That read clears the flag. The flag is merged into the status byte the unit returns, and it drives the last jump condition. A program can therefore poll the port with a conditional jump.

Top module: `br_cond_unit`

## Requirements
- R1: After reset the input-available flag is 0, the input register holds 0 and `in_ready_o` is 1.
- R2: When `is_jump_i` is 0, `take_o` is 0 whatever the other inputs are.
- R3: For a jump with `cond_sel_i` 0 or 1, `take_o` is 1 in the same cycle regardless of the status byte.
- R4: For a jump, `cond_sel_i` 2/3 follows carry (status bit 7), 4/5 follows overflow (bit 6), 6/7 follows zero (bit 5) and 8/9 follows negative (bit 4), combinationally.
- R5: For a jump, `cond_sel_i` 10/11 follows greater (status bit 3) and 12/13 follows less (status bit 2).
- R6: For a jump, `cond_sel_i` 14/15 follows the unit's own input-available flag. Bit 1 of `flags_i` has no effect on it.
- R7: `src_imm_o` equals bit 0 of `cond_sel_i`: 0 selects H:L, 1 selects the immediate address.
- R8: A strobe on `in_valid_i` while the flag is 0 and `rd_in_i` is 0 loads `in_data_i` into the input register. After that edge the flag is 1 and `in_ready_o` is 0.
- R9: While the flag is 1, strobes on `in_valid_i` leave the input register unchanged.
- R10: A cycle with `rd_in_i` high clears the flag at the next edge, and `in_ready_o` returns to 1.
- R11: When `rd_in_i` and `in_valid_i` are high in the same cycle, the clear wins. The arriving byte is dropped, the register keeps its old value and the flag ends at 0.
- R12: `status_o` carries `flags_i` bits 7..2 unchanged, the input-available flag at bit 1 and 0 at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_jump_i | input | 1 | Current instruction is a jump |
| cond_sel_i | input | 4 | Lower nibble of the jump opcode |
| flags_i | input | 8 | Status byte from the ALU (C,V,Z,N,G,L at bits 7..2) |
| take_o | output | 1 | Jump taken |
| src_imm_o | output | 1 | Target source: 1 immediate, 0 H:L pair |
| status_o | output | 8 | Status byte with the input-available flag merged at bit 1 |
| in_data_i | input | 8 | Byte from the input port |
| in_valid_i | input | 1 | One-cycle strobe for in_data_i |
| in_ready_o | output | 1 | Port can accept a byte (flag clear) |
| rd_in_i | input | 1 | CPU reads the input register this cycle |
| in_reg_o | output | 8 | Input register contents |

## Verification
The bench sweeps all sixteen selector values against one-hot and mixed status bytes. A swapped flag bit position, or a decode that ignores the pair structure, would take the wrong jumps. The input-condition pair is tested with status bit 1 set opposite to the real flag, so a design that reads the external bit instead of its own flag fails. Strobes are sent while the flag is set, which exposes a design that overwrites unread data. A strobe that lands together with a read checks that the clear wins and the byte is lost rather than latched.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned N_COND  = 1 << (SEL_W - 1);

  localparam int unsigned BIT_C   = 7;
  localparam int unsigned BIT_V   = 6;
  localparam int unsigned BIT_Z   = 5;
  localparam int unsigned BIT_N   = 4;
  localparam int unsigned BIT_G   = 3;
  localparam int unsigned BIT_L   = 2;
  localparam int unsigned BIT_I   = 1;

  typedef enum logic [SEL_W-2:0] {
    COND_ALWAYS = 3'd0,
    COND_CARRY  = 3'd1,
    COND_OVF    = 3'd2,
    COND_ZERO   = 3'd3,
    COND_NEG    = 3'd4,
    COND_GT     = 3'd5,
    COND_LT     = 3'd6,
    COND_INPUT  = 3'd7
  } cond_e;

  // status bit tested by each flag-based condition
  function automatic int unsigned cond_bit(input int unsigned c);
    case (c)
      1:       return BIT_C;
      2:       return BIT_V;
      3:       return BIT_Z;
      4:       return BIT_N;
      5:       return BIT_G;
      6:       return BIT_L;
      default: return BIT_I;
    endcase
  endfunction
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic              is_jump_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic              in_flag_i,
  output logic              take_o,
  output logic              src_imm_o
);
  localparam int unsigned IDX_W = SEL_W - 1;

  logic [N_COND-1:0] cond_vec;
  logic [IDX_W-1:0]  cond_idx;

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    if (g == int'(COND_ALWAYS)) begin : g_always
      assign cond_vec[g] = 1'b1;
    end else if (g == int'(COND_INPUT)) begin : g_input
      // owned flag, never the incoming status bit
      assign cond_vec[g] = in_flag_i;
    end else begin : g_flag
      assign cond_vec[g] = flags_i[cond_bit(g)];
    end
  end

  assign cond_idx  = sel_i[SEL_W-1:1];
  assign take_o    = is_jump_i & cond_vec[cond_idx];
  assign src_imm_o = sel_i[0];
endmodule

// File: rtl/br_in_port.sv
module br_in_port
  import br_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_o
);
  logic              flag_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  // read clear outranks an arriving byte
  assign load = valid_i & ~flag_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (rd_i)      flag_q <= 1'b0;
      else if (load) flag_q <= 1'b1;
      if (load)      data_q <= data_i;
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/br_status_merge.sv
module br_status_merge
  import br_pkg::*;
(
  input  logic [DATA_W-1:0] flags_i,
  input  logic              in_flag_i,
  output logic [DATA_W-1:0] status_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == int'(BIT_I)) begin : g_i
      assign status_o[b] = in_flag_i;
    end else if (b < int'(BIT_I)) begin : g_rsvd
      assign status_o[b] = 1'b0;
    end else begin : g_pass
      assign status_o[b] = flags_i[b];
    end
  end
endmodule

// File: rtl/br_cond_unit.sv
module br_cond_unit
  import br_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_jump_i,
  input  logic [SEL_W-1:0]  cond_sel_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic              take_o,
  output logic              src_imm_o,
  output logic [DATA_W-1:0] status_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              rd_in_i,
  output logic [DATA_W-1:0] in_reg_o
);
  logic in_flag;

  br_in_port u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (in_data_i),
    .valid_i (in_valid_i),
    .rd_i    (rd_in_i),
    .data_o  (in_reg_o),
    .flag_o  (in_flag)
  );

  br_cond_eval u_eval (
    .is_jump_i (is_jump_i),
    .sel_i     (cond_sel_i),
    .flags_i   (flags_i),
    .in_flag_i (in_flag),
    .take_o    (take_o),
    .src_imm_o (src_imm_o)
  );

  br_status_merge u_merge (
    .flags_i   (flags_i),
    .in_flag_i (in_flag),
    .status_o  (status_o)
  );

  assign in_ready_o = ~in_flag;
endmodule

// File: rtl/br_cond_chk.sv
module br_cond_chk
  import br_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              is_jump_i,
  input logic [SEL_W-1:0]  cond_sel_i,
  input logic              take_o,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              rd_in_i,
  input logic [DATA_W-1:0] in_reg_o
);
  assert_nojump_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_jump_i |-> !take_o);

  assert_always_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_jump_i && cond_sel_i[SEL_W-1:1] == '0) |-> take_o);

  assert_load_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !rd_in_i) |=>
      (status_o[BIT_I] && in_reg_o == $past(in_data_i)));

  assert_no_overwrite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[BIT_I] |=> $stable(in_reg_o));

  assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in_i |=> (!status_o[BIT_I] && in_ready_o));

  assert_flag_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[BIT_I]) |-> $past(in_valid_i));

  assert_collide_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_in_i && in_valid_i) |=> $stable(in_reg_o));
endmodule

bind br_cond_unit br_cond_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .is_jump_i  (is_jump_i),
  .cond_sel_i (cond_sel_i),
  .take_o     (take_o),
  .status_o   (status_o),
  .in_data_i  (in_data_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .rd_in_i    (rd_in_i),
  .in_reg_o   (in_reg_o)
);

// File: tb/sim_br_cond_unit.sv
`timescale 1ns/1ps
module sim_br_cond_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       is_jump_i = 1'b0;
  logic [3:0] cond_sel_i = '0;
  logic [7:0] flags_i = '0;
  logic       take_o, src_imm_o, in_ready_o;
  logic [7:0] status_o, in_reg_o;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0;
  logic       rd_in_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  br_cond_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .is_jump_i(is_jump_i), .cond_sel_i(cond_sel_i),
    .flags_i(flags_i), .take_o(take_o), .src_imm_o(src_imm_o), .status_o(status_o),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .rd_in_i(rd_in_i), .in_reg_o(in_reg_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_take(input logic j, input logic [3:0] s,
                                    input logic [7:0] f, input logic iflag);
    logic r;
    case (s[3:1])
      3'd0: r = 1'b1;
      3'd1: r = f[7];
      3'd2: r = f[6];
      3'd3: r = f[5];
      3'd4: r = f[4];
      3'd5: r = f[3];
      3'd6: r = f[2];
      default: r = iflag;
    endcase
    return j & r;
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 flag", {7'd0, status_o[1]}, 8'h00);
    chk("R1 in_reg", in_reg_o, 8'h00);
    chk("R1 ready", {7'd0, in_ready_o}, 8'h01);
  endtask

  task automatic t_sweep(input logic iflag);
    logic [7:0] pats [10] = '{8'h00, 8'hFF, 8'h80, 8'h40, 8'h20, 8'h10,
                              8'h08, 8'h04, 8'h02, 8'hFD};
    for (int p = 0; p < 10; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int j = 0; j < 2; j++) begin
          @(negedge clk_i);
          is_jump_i = j[0]; cond_sel_i = s[3:0]; flags_i = pats[p];
          #1;
          if (j == 0) chk("R2 no jump", {7'd0, take_o}, 8'h00);
          else if (s < 2) chk("R3 always", {7'd0, take_o}, 8'h01);
          else if (s < 10) chk("R4 cvzn", {7'd0, take_o},
                               {7'd0, exp_take(1'b1, s[3:0], pats[p], iflag)});
          else if (s < 14) chk("R5 gt/lt", {7'd0, take_o},
                               {7'd0, exp_take(1'b1, s[3:0], pats[p], iflag)});
          else chk("R6 input cond", {7'd0, take_o}, {7'd0, iflag});
          chk("R7 src", {7'd0, src_imm_o}, {7'd0, s[0]});
          chk("R12 status", status_o, {pats[p][7:2], iflag, 1'b0});
        end
      end
    end
    @(negedge clk_i);
    is_jump_i = 1'b0; flags_i = '0;
  endtask

  task automatic t_load(input logic [7:0] d);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = d;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1;
    chk("R8 data", in_reg_o, d);
    chk("R8 flag", {7'd0, status_o[1]}, 8'h01);
    chk("R8 ready", {7'd0, in_ready_o}, 8'h00);
  endtask

  task automatic t_blocked(input logic [7:0] held);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1; in_data_i = held ^ 8'h5A ^ 8'(k);
      @(negedge clk_i);
      in_valid_i = 1'b0;
      #1;
      chk("R9 held", in_reg_o, held);
      chk("R9 flag", {7'd0, status_o[1]}, 8'h01);
    end
  endtask

  task automatic t_read(input logic [7:0] held);
    @(negedge clk_i);
    rd_in_i = 1'b1;
    @(negedge clk_i);
    rd_in_i = 1'b0;
    #1;
    chk("R10 flag", {7'd0, status_o[1]}, 8'h00);
    chk("R10 ready", {7'd0, in_ready_o}, 8'h01);
    chk("R10 data", in_reg_o, held);
  endtask

  task automatic t_collide(input logic [7:0] held);
    @(negedge clk_i);
    rd_in_i = 1'b1; in_valid_i = 1'b1; in_data_i = ~held;
    @(negedge clk_i);
    rd_in_i = 1'b0; in_valid_i = 1'b0;
    #1;
    chk("R11 dropped", in_reg_o, held);
    chk("R11 flag", {7'd0, status_o[1]}, 8'h00);
  endtask

  task automatic t_input_jump(input logic iflag);
    @(negedge clk_i);
    is_jump_i = 1'b1; flags_i = iflag ? 8'h00 : 8'h02;
    for (int s = 14; s < 16; s++) begin
      cond_sel_i = s[3:0];
      #1;
      chk("R6 own flag", {7'd0, take_o}, {7'd0, iflag});
      #1;
    end
    is_jump_i = 1'b0; flags_i = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sweep(1'b0);
    t_input_jump(1'b0);
    t_load(8'hA5);
    t_sweep(1'b1);
    t_input_jump(1'b1);
    t_blocked(8'hA5);
    t_collide(8'hA5);
    t_load(8'h3C);
    t_read(8'h3C);
    t_collide(8'h3C);
    t_load(8'hC3);
    t_read(8'hC3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule